// File: doc/BRIEF.md
# Qualified Multi-Stage Reset Sequencer

This block drives eight active-high reset outputs for a serial-link subsystem that has a transmit path and a receive path. It takes them out of reset in a strict order: the clock-generator PLL, the transceiver, then the transmit control registers, transmit link layer and transmit frame layer, and finally the same three domains for the receive side. The link-layer reset covers the link core together with the transport logic. The frame-layer reset covers the transport logic and the data modules upstream and downstream of it. Each release waits for the ready qualifier that guards it. A release then happens a fixed number of hold-off cycles after that qualifier has been seen.

A restart comes from two sources. One is the asynchronous active-low hard reset pin. The other is a soft-reset bit written through a small register port. Either source puts every output back into reset and runs the whole release sequence again from the beginning. When a qualifier drops while its dependent domains are already running, the sequencer puts the first dependent domain and every later domain back into reset. It then resumes from the step that waits on that qualifier. The receive domains are released only after all three transmit domains, so an early receive-ready cannot free them first.

Top module: `link_reset_sequencer`

## Requirements
- R1: While hard_rst_n is low, all eight reset outputs are 1. They go to 1 immediately on its falling edge, without waiting for a clock edge. The status stage field reads 0.
- R2: The outputs are released one at a time, in the order pll_rst, xcvr_rst, tx_csr_rst, tx_link_rst, tx_frame_rst, rx_csr_rst, rx_link_rst, rx_frame_rst. A domain is never out of reset while an earlier one is still held. Each release follows its qualifier by HOLDOFF clock cycles. The hard reset and all qualifiers pass through two-flop synchronisers before they take effect.
- R3: xcvr_rst is released only after the synchronised pll_locked has been high for LOCK_CYCLES consecutive cycles. A shorter high pulse does not release it.
- R4: tx_csr_rst, tx_link_rst and tx_frame_rst are released only while the synchronised tx_xcvr_ready is high.
- R5: The receive resets stay asserted until tx_frame_rst has been released, even when rx_xcvr_ready rises first. After that, they are released only while rx_xcvr_ready is high.
- R6: A register write with reg_addr=0 and reg_wdata[0]=1 sets a soft-reset bit, which reads back as bit 0 at address 0. On the next clock edge the bit clears itself, all outputs return to 1, and the full sequence restarts.
- R7: Reading reg_addr=1 returns the stage in bits [3:0], which is the number of released domains (0 to 8). Bit 8 is the done flag (stage 8). All other bits read 0.
- R8: If pll_locked drops while xcvr_rst is released, xcvr_rst and all later outputs return to 1, and the sequence resumes by waiting for a new lock period.
- R9: If tx_xcvr_ready drops while tx_csr_rst is released, tx_csr_rst and all later outputs return to 1, and the sequence resumes at the transmit control-register step.
- R10: If rx_xcvr_ready drops while rx_csr_rst is released, the three receive resets return to 1, and the sequence resumes at the receive control-register step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| hard_rst_n | input | 1 | Asynchronous hard reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 = control, 1 = status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| pll_locked | input | 1 | PLL lock qualifier (asynchronous) |
| tx_xcvr_ready | input | 1 | Transmit transceiver ready (asynchronous) |
| rx_xcvr_ready | input | 1 | Receive transceiver ready (asynchronous) |
| pll_rst | output | 1 | Core PLL reset |
| xcvr_rst | output | 1 | Transceiver reset |
| tx_csr_rst | output | 1 | Transmit control-register reset |
| tx_link_rst | output | 1 | Transmit link-layer reset |
| tx_frame_rst | output | 1 | Transmit frame-layer reset |
| rx_csr_rst | output | 1 | Receive control-register reset |
| rx_link_rst | output | 1 | Receive link-layer reset |
| rx_frame_rst | output | 1 | Receive frame-layer reset |

## Verification
The bench raises receive-ready long before transmit-ready. A sequencer without the interlock would free the receive domains while the transmit side is still held. It gives the PLL lock a pulse shorter than the lock window, which a design that looks only at the level would accept. It drops each of the three qualifiers in turn once the sequence has finished. A design that rolled back to the wrong step, or failed to reassert the later domains, would show the wrong output vector in the next cycles. It also checks that a soft reset and a hard reset asserted mid-sequence both bring all outputs back to 1, and that a hard reset does so without a clock edge. A design that waited for a clock edge, or left the soft bit set, would be caught.

// File: rtl/link_reset_sequencer.sv
module link_reset_sequencer #(
  parameter int LOCK_CYCLES = 16,
  parameter int HOLDOFF     = 4
) (
  input  logic        clk,
  input  logic        hard_rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        pll_locked,
  input  logic        tx_xcvr_ready,
  input  logic        rx_xcvr_ready,
  output logic        pll_rst,
  output logic        xcvr_rst,
  output logic        tx_csr_rst,
  output logic        tx_link_rst,
  output logic        tx_frame_rst,
  output logic        rx_csr_rst,
  output logic        rx_link_rst,
  output logic        rx_frame_rst
);

  localparam int LW = $clog2(LOCK_CYCLES + 1);
  localparam int HW = (HOLDOFF > 1) ? $clog2(HOLDOFF) : 1;
  localparam int NDOM = 8;
  localparam logic [LW-1:0] LOCK_MAX  = LW'(LOCK_CYCLES);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLDOFF - 1);
  localparam logic [3:0] ST_LOCK = 4'd1, ST_TX = 4'd2, ST_TX_LINK = 4'd3,
                         ST_RX = 4'd5, ST_RX_LINK = 4'd6, ST_DONE = 4'd8;

  logic [1:0] rsync;
  logic       rst_n_int;
  logic [2:0] qa, qb;
  logic       pll_s, tx_s, rx_s;
  logic [LW-1:0] lock_cnt;
  logic       lock_ok, soft_q, qual;
  logic [HW-1:0] cnt_q, cnt_d;
  logic [3:0] stage_q, stage_d;
  logic [NDOM-1:0] held_q;

  always_ff @(posedge clk or negedge hard_rst_n)
    if (!hard_rst_n) rsync <= 2'b00;
    else             rsync <= {rsync[0], 1'b1};
  assign rst_n_int = rsync[1];

  always_ff @(posedge clk or negedge rst_n_int)
    if (!rst_n_int) begin
      qa <= '0;
      qb <= '0;
    end else begin
      qa <= {rx_xcvr_ready, tx_xcvr_ready, pll_locked};
      qb <= qa;
    end
  assign pll_s = qb[0];
  assign tx_s  = qb[1];
  assign rx_s  = qb[2];

  always_ff @(posedge clk or negedge rst_n_int)
    if (!rst_n_int)           lock_cnt <= '0;
    else if (!pll_s)          lock_cnt <= '0;
    else if (!lock_ok)        lock_cnt <= lock_cnt + 1'b1;
  assign lock_ok = (lock_cnt == LOCK_MAX);

  always_ff @(posedge clk or negedge rst_n_int)
    if (!rst_n_int) soft_q <= 1'b0;
    else            soft_q <= reg_wr && !reg_addr && reg_wdata[0];

  always_comb begin
    case (stage_q)
      4'd0:             qual = 1'b1;
      ST_LOCK:          qual = lock_ok;
      4'd2, 4'd3, 4'd4: qual = tx_s;
      4'd5, 4'd6, 4'd7: qual = rx_s;
      default:          qual = 1'b0;
    endcase
    stage_d = stage_q;
    cnt_d   = cnt_q;
    if (soft_q) begin
      stage_d = 4'd0;
      cnt_d   = '0;
    end else if (stage_q >= ST_TX && !pll_s) begin
      stage_d = ST_LOCK;
      cnt_d   = '0;
    end else if (stage_q >= ST_TX_LINK && !tx_s) begin
      stage_d = ST_TX;
      cnt_d   = '0;
    end else if (stage_q >= ST_RX_LINK && !rx_s) begin
      stage_d = ST_RX;
      cnt_d   = '0;
    end else if (!qual) begin
      cnt_d = '0;
    end else if (cnt_q == HOLD_LAST) begin
      stage_d = stage_q + 4'd1;
      cnt_d   = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int)
    if (!rst_n_int) begin
      stage_q <= '0;
      cnt_q   <= '0;
      held_q  <= '1;
    end else begin
      stage_q <= stage_d;
      cnt_q   <= cnt_d;
      for (int i = 0; i < NDOM; i++) held_q[i] <= (stage_d <= 4'(i));
    end

  assign pll_rst      = held_q[0];
  assign xcvr_rst     = held_q[1];
  assign tx_csr_rst   = held_q[2];
  assign tx_link_rst  = held_q[3];
  assign tx_frame_rst = held_q[4];
  assign rx_csr_rst   = held_q[5];
  assign rx_link_rst  = held_q[6];
  assign rx_frame_rst = held_q[7];

  assign reg_rdata = reg_addr ? {23'd0, stage_q == ST_DONE, 4'd0, stage_q}
                              : {31'd0, soft_q};

  a_r2_pll_before_xcvr: assert property (@(posedge clk) disable iff (!rst_n_int)
    !xcvr_rst |-> !pll_rst);
  a_r3_lock_window: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(xcvr_rst) |-> $past(lock_ok));
  a_r4_tx_qualified: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(tx_csr_rst) |-> $past(tx_s));
  a_r5_rx_after_tx: assert property (@(posedge clk) disable iff (!rst_n_int)
    !rx_csr_rst |-> !tx_frame_rst);
  a_r6_soft_restart: assert property (@(posedge clk) disable iff (!rst_n_int)
    soft_q |=> (pll_rst && rx_frame_rst && !soft_q));
  a_r8_lock_loss: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!xcvr_rst && !pll_s) |=> xcvr_rst);
  a_r9_tx_loss: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!tx_csr_rst && !tx_s) |=> tx_csr_rst);
  a_r10_rx_loss: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!rx_csr_rst && !rx_s) |=> rx_csr_rst);

endmodule

// File: tb/link_reset_sequencer_tb_top.sv
module link_reset_sequencer_tb_top;
  localparam int LOCK = 16;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic hard_rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic pll_locked = 1'b0, tx_xcvr_ready = 1'b0, rx_xcvr_ready = 1'b0;
  logic pll_rst, xcvr_rst, tx_csr_rst, tx_link_rst, tx_frame_rst;
  logic rx_csr_rst, rx_link_rst, rx_frame_rst;

  link_reset_sequencer #(.LOCK_CYCLES(LOCK), .HOLDOFF(HOLD)) dut_i (
    .clk(clk), .hard_rst_n(hard_rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pll_locked(pll_locked),
    .tx_xcvr_ready(tx_xcvr_ready), .rx_xcvr_ready(rx_xcvr_ready),
    .pll_rst(pll_rst), .xcvr_rst(xcvr_rst), .tx_csr_rst(tx_csr_rst),
    .tx_link_rst(tx_link_rst), .tx_frame_rst(tx_frame_rst),
    .rx_csr_rst(rx_csr_rst), .rx_link_rst(rx_link_rst), .rx_frame_rst(rx_frame_rst));

  int n_chk = 0, n_fail = 0, cycles = 0;
  string cur_req = "R1";

  // reference model: behavioural state in integers
  bit m_rs0, m_rs1, m_soft;
  bit m_pll[$], m_tx[$], m_rx[$];
  int m_lock, m_cnt, m_stage;

  function automatic bit qhead(ref bit q[$]);
    return q[0];
  endfunction

  task automatic model_clear();
    m_pll = '{0, 0}; m_tx = '{0, 0}; m_rx = '{0, 0};
    m_lock = 0; m_cnt = 0; m_stage = 0; m_soft = 0;
  endtask

  initial model_clear();

  always @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      m_rs0 = 0; m_rs1 = 0;
      model_clear();
    end else begin
      if (!m_rs1) model_clear();
      else begin
        bit p, t, r, ok, q;
        int ns, nc;
        p = qhead(m_pll); t = qhead(m_tx); r = qhead(m_rx);
        ok = (m_lock == LOCK);
        if (m_stage == 0) q = 1;
        else if (m_stage == 1) q = ok;
        else if (m_stage <= 4) q = t;
        else if (m_stage <= 7) q = r;
        else q = 0;
        ns = m_stage; nc = m_cnt;
        if (m_soft) begin ns = 0; nc = 0; end
        else if (m_stage >= 2 && !p) begin ns = 1; nc = 0; end
        else if (m_stage >= 3 && !t) begin ns = 2; nc = 0; end
        else if (m_stage >= 6 && !r) begin ns = 5; nc = 0; end
        else if (!q) nc = 0;
        else if (m_cnt == HOLD - 1) begin ns = m_stage + 1; nc = 0; end
        else nc = m_cnt + 1;
        m_lock = !p ? 0 : (ok ? m_lock : m_lock + 1);
        m_stage = ns; m_cnt = nc;
        m_soft = reg_wr && !reg_addr && reg_wdata[0];
        void'(m_pll.pop_front()); m_pll.push_back(pll_locked);
        void'(m_tx.pop_front());  m_tx.push_back(tx_xcvr_ready);
        void'(m_rx.pop_front());  m_rx.push_back(rx_xcvr_ready);
      end
      m_rs1 = m_rs0; m_rs0 = 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] outs();
    return {24'd0, rx_frame_rst, rx_link_rst, rx_csr_rst, tx_frame_rst,
            tx_link_rst, tx_csr_rst, xcvr_rst, pll_rst};
  endfunction

  function automatic logic [31:0] exp_outs();
    logic [31:0] v = '0;
    for (int i = 0; i < 8; i++) v[i] = (m_stage <= i);
    return v;
  endfunction

  function automatic logic [31:0] exp_rdata();
    if (reg_addr) return {23'd0, m_stage == 8, 4'd0, 4'(m_stage)};
    return {31'd0, m_soft};
  endfunction

  always @(negedge clk) begin
    chk(cur_req, outs(), exp_outs());
    chk(cur_req, reg_rdata, exp_rdata());
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 200000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<200000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  initial begin
    reg_addr = 1'b1;
    tick(5);
    chk("R1", outs(), 32'hFF);
    chk("R1", reg_rdata, 32'h0);
    cur_req = "R2";
    hard_rst_n = 1'b1;
    tick(12);
    chk("R2", outs(), 32'hFE);
    cur_req = "R3";
    pll_locked = 1'b1; tick(6); pll_locked = 1'b0; tick(30);
    chk("R3", {31'd0, xcvr_rst}, 32'd1);
    cur_req = "R5";
    pll_locked = 1'b1; rx_xcvr_ready = 1'b1;
    tick(60);
    chk("R5", {31'd0, rx_csr_rst}, 32'd1);
    chk("R4", {31'd0, tx_csr_rst}, 32'd1);
    cur_req = "R4";
    tx_xcvr_ready = 1'b1;
    tick(60);
    cur_req = "R7";
    chk("R7", reg_rdata, 32'h108);
    cur_req = "R10";
    rx_xcvr_ready = 1'b0; tick(8);
    chk("R10", outs(), 32'hE0);
    rx_xcvr_ready = 1'b1; tick(40);
    cur_req = "R9";
    tx_xcvr_ready = 1'b0; tick(8);
    chk("R9", outs(), 32'hFC);
    tx_xcvr_ready = 1'b1; tick(60);
    cur_req = "R8";
    pll_locked = 1'b0; tick(8);
    chk("R8", outs(), 32'hFE);
    pll_locked = 1'b1; tick(80);
    chk("R8", reg_rdata, 32'h108);
    cur_req = "R6";
    reg_addr = 1'b0; reg_wdata = 32'h1; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0;
    chk("R6", reg_rdata, 32'h1);
    tick(1);
    chk("R6", reg_rdata, 32'h0);
    chk("R6", outs(), 32'hFF);
    reg_addr = 1'b1;
    tick(80);
    chk("R6", reg_rdata, 32'h108);
    cur_req = "R1";
    hard_rst_n = 1'b0;
    #1;
    chk("R1", outs(), 32'hFF);
    tick(3);
    hard_rst_n = 1'b1;
    cur_req = "R2";
    tick(100);
    chk("R2", reg_rdata, 32'h108);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule